// File: doc/BRIEF.md
# Condition Code Flag Shifter

This block is the four-bit flag register of a microcoded processor. Bit 0 holds carry, bit 1 holds negative, and bits 2 and 3 hold the two remaining condition flags. On an ordinary cycle the microcode either keeps the flags or captures all four at once from the ALU's flag outputs. The parallel inputs of the register connect only to the ALU. Any other value therefore has to come in through a serial path. When the processor returns from an interrupt, the microcode rebuilds the flags it saved by shifting them in one bit per clock. The value for bit 0 goes first and each new bit enters at bit 3.

The same right shift also supports an older way of testing flags. Each shift moves the next flag into bit 0, so carry can be tested at once, negative after one shift, and the other two flags after two or three shifts. A serial output always shows bit 0, which lets the flags be saved one bit at a time. All four flags also appear in parallel as the low nibble of a 16-bit microcode address. The upper bits of that address are the 8-bit opcode and the 4-bit phase.

The control path is a three-way operation select: HOLD, LOAD and SHIFT. It is decoded again on every cycle from the two enable inputs, and LOAD takes priority over SHIFT. The transitions are HOLD→HOLD when neither enable is set, any→LOAD when load is set, and any→SHIFT when only shift is set.

Top module: `cc_flag_shifter`

## Requirements
- R1: While `rst_n` is low, all four flags are 0 and any load or shift request is ignored.
- R2: With `load_en` high, the flags equal `alu_flags` after the next rising clock edge.
- R3: With `shift_en` high and `load_en` low, the next flags are `{ser_in, flags[3:1]}`, so `ser_in` enters bit 3 and the old bit 0 is dropped.
- R4: When `load_en` and `shift_en` are both high, the flags take `alu_flags` and no shift happens.
- R5: With both enables low, the flags keep their value.
- R6: `ser_out` always equals flag bit 0, which is carry.
- R7: `uaddr` is `{opcode, phase, flags}`: the opcode in bits 15:8, the phase in bits 7:4, carry in bit 0 and negative in bit 1.
- R8: Four shift cycles that supply a saved nibble from bit 0 to bit 3 leave the flags equal to that nibble, whatever the flags held before.
- R9: After k shift cycles from a loaded value, the flag that was loaded into bit k sits in bit 0 and on `ser_out`. Carry needs 0 shifts and negative needs 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_flags | input | 4 | Flag outputs of the ALU (bit0 carry, bit1 negative) |
| load_en | input | 1 | Capture all four flags from `alu_flags` |
| shift_en | input | 1 | Shift flags right by one, with `ser_in` entering bit 3 |
| ser_in | input | 1 | Serial restore data |
| opcode | input | 8 | Current opcode, used for the microcode address |
| phase | input | 4 | Current microcode phase |
| flags | output | 4 | Current flag values |
| ser_out | output | 1 | Serial output, equal to flag bit 0 |
| uaddr | output | 16 | Microcode address {opcode, phase, flags} |

## Verification
Parallel load and serial shift can be requested in the same cycle. The bench sets both enables together with `alu_flags` chosen to differ from the shifted result, and it also uses a `ser_in` value that would show up in bit 3 if the shift won. A scoreboard entry then expects the exact ALU nibble, and every entry also checks `ser_out` and the complete `uaddr`. Restore sequences start from non-zero flags, so a bit left over from the old value cannot pass as a restored one.

// File: rtl/cc_pkg.sv
package cc_pkg;
    // Operation selected for the flag register on each cycle
    typedef enum logic [1:0] {
        CC_HOLD  = 2'd0,
        CC_LOAD  = 2'd1,
        CC_SHIFT = 2'd2
    } cc_op_e;
endpackage

// File: rtl/cc_op_decode.sv
module cc_op_decode
    import cc_pkg::*;
(
    input  logic   load_en,
    input  logic   shift_en,
    output cc_op_e op
);
    // Load has priority over shift (R4)
    always_comb begin
        if (load_en)       op = CC_LOAD;
        else if (shift_en) op = CC_SHIFT;
        else               op = CC_HOLD;
    end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_pkg::*;
#(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cc_op_e           op,
    input  logic [NFLAG-1:0] par_in,
    input  logic             ser_in,
    output logic [NFLAG-1:0] q
);
    logic [NFLAG-1:0] q_next;

    // Next-value selection
    always_comb begin
        q_next = q;
        unique case (op)
            CC_HOLD:  q_next = q;
            CC_LOAD:  q_next = par_in;
            CC_SHIFT: q_next = {ser_in, q[NFLAG-1:1]};
            default:  q_next = q;
        endcase
    end

    // Storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end
endmodule

// File: rtl/cc_uaddr_pack.sv
module cc_uaddr_pack #(
    parameter int OPC_W = 8,
    parameter int PH_W  = 4,
    parameter int NFLAG = 4,
    localparam int AW   = OPC_W + PH_W + NFLAG
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [PH_W-1:0]  phase,
    input  logic [NFLAG-1:0] flags,
    output logic [AW-1:0]    uaddr
);
    assign uaddr = {opcode, phase, flags};
endmodule

// File: rtl/cc_flag_shifter.sv
module cc_flag_shifter
    import cc_pkg::*;
#(
    parameter int NFLAG = 4,
    parameter int OPC_W = 8,
    parameter int PH_W  = 4,
    localparam int AW   = OPC_W + PH_W + NFLAG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] alu_flags,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [OPC_W-1:0] opcode,
    input  logic [PH_W-1:0]  phase,
    output logic [NFLAG-1:0] flags,
    output logic             ser_out,
    output logic [AW-1:0]    uaddr
);
    cc_op_e op;

    cc_op_decode u_dec (
        .load_en  (load_en),
        .shift_en (shift_en),
        .op       (op)
    );

    cc_flag_reg #(.NFLAG(NFLAG)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_in (alu_flags),
        .ser_in (ser_in),
        .q      (flags)
    );

    cc_uaddr_pack #(.OPC_W(OPC_W), .PH_W(PH_W), .NFLAG(NFLAG)) u_pack (
        .opcode (opcode),
        .phase  (phase),
        .flags  (flags),
        .uaddr  (uaddr)
    );

    assign ser_out = flags[0];

    // R2: a load request captures the ALU flags
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load_en) |-> flags == $past(alu_flags));

    // R4: with both requests set, the result is the load and not the shift
    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load_en) && $past(shift_en)
        |-> flags == $past(alu_flags));

    // R3: shift only brings serial data into the top bit
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load_en) && $past(shift_en)
        |-> flags == {$past(ser_in), $past(flags[NFLAG-1:1])});

    // R5: with no request the flags hold their value
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load_en) && !$past(shift_en) |-> $stable(flags));

    // R6: a shift brings the old bit 1 out on the serial output
    p_serout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load_en) && $past(shift_en)
        |-> ser_out == $past(flags[1]));
endmodule

// File: tb/cc_flag_shifter_test.sv
module cc_flag_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  alu_flags;
    logic        load_en, shift_en, ser_in;
    logic [7:0]  opcode;
    logic [3:0]  phase;
    logic [3:0]  flags;
    logic        ser_out;
    logic [15:0] uaddr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] model;

    typedef struct {
        logic [3:0]  f;
        logic [15:0] a;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    cc_flag_shifter uut (
        .clk(clk), .rst_n(rst_n), .alu_flags(alu_flags),
        .load_en(load_en), .shift_en(shift_en), .ser_in(ser_in),
        .opcode(opcode), .phase(phase),
        .flags(flags), .ser_out(ser_out), .uaddr(uaddr)
    );

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic drive(input logic ld, input logic sh, input logic si,
                         input logic [3:0] alu, input logic [7:0] opc,
                         input logic [3:0] ph, input string tag);
        exp_t e;
        @(negedge clk);
        load_en = ld; shift_en = sh; ser_in = si;
        alu_flags = alu; opcode = opc; phase = ph;
        if (ld)      model = alu;
        else if (sh) model = {si, model[3:1]};
        e.f = model;
        e.a = {opc, ph, model};
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Restore a saved nibble, bit 0 first
    task automatic restore(input logic [3:0] saved, input logic [7:0] opc,
                           input string tag);
        for (int i = 0; i < 4; i++)
            drive(1'b0, 1'b1, saved[i], ~saved, opc, 4'(i), tag);
    endtask

    // Monitor: compare outputs one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (flags !== e.f || ser_out !== e.f[0] || uaddr !== e.a) begin
                n_fail++;
                $display("FAIL %s: flags=%h ser_out=%b uaddr=%h, expected flags=%h ser_out=%b uaddr=%h",
                         e.tag, flags, ser_out, uaddr, e.f, e.f[0], e.a);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model = 4'h0;
        rst_n = 1'b0;
        load_en = 1'b1; shift_en = 1'b1; ser_in = 1'b1;
        alu_flags = 4'hF; opcode = 8'h00; phase = 4'h0;
        repeat (3) @(negedge clk);
        // R1: reset clears and ignores requests
        n_tests++;
        if (flags !== 4'h0 || ser_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: flags=%h ser_out=%b, expected flags=0 ser_out=0", flags, ser_out);
        end
        load_en = 1'b0; shift_en = 1'b0;
        rst_n = 1'b1;

        // R2 / R7: parallel loads under several patterns
        drive(1'b1, 1'b0, 1'b0, 4'h5, 8'h3C, 4'h2, "R2 load 5");
        drive(1'b1, 1'b0, 1'b1, 4'hA, 8'hC3, 4'h9, "R2 load A");
        drive(1'b1, 1'b0, 1'b0, 4'h1, 8'hFF, 4'hF, "R7 carry in bit0");
        drive(1'b1, 1'b0, 1'b0, 4'h2, 8'h00, 4'h0, "R7 negative in bit1");
        // R5: hold with changing ALU flags
        drive(1'b0, 1'b0, 1'b1, 4'hD, 8'h81, 4'h4, "R5 hold");
        drive(1'b0, 1'b0, 1'b0, 4'hF, 8'h18, 4'h5, "R5 hold");
        // R3 / R6: single shifts
        drive(1'b1, 1'b0, 1'b0, 4'h6, 8'h42, 4'h1, "R3 preload");
        drive(1'b0, 1'b1, 1'b1, 4'h0, 8'h42, 4'h2, "R3 shift in 1");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h42, 4'h3, "R6 shift in 0");
        // R4: both requested, load wins
        drive(1'b1, 1'b1, 1'b1, 4'h3, 8'h99, 4'h7, "R4 load over shift");
        drive(1'b1, 1'b1, 1'b0, 4'hC, 8'h66, 4'h8, "R4 load over shift");
        // R8: serial restore from non-zero state
        drive(1'b1, 1'b0, 1'b0, 4'hF, 8'h01, 4'h0, "R8 preload");
        restore(4'hA, 8'h01, "R8 restore A");
        drive(1'b1, 1'b0, 1'b0, 4'h9, 8'h02, 4'h0, "R8 preload");
        restore(4'h6, 8'h02, "R8 restore 6");
        drive(1'b0, 1'b0, 1'b0, 4'h0, 8'h02, 4'hE, "R8 hold after restore");
        // R9: legacy test shifts bring flag k to bit 0
        drive(1'b1, 1'b0, 1'b0, 4'h4, 8'h10, 4'h0, "R9 flag2 only");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 4'h1, "R9 one shift");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 4'h2, "R9 flag2 at bit0");
        drive(1'b1, 1'b0, 1'b0, 4'h8, 8'h11, 4'h0, "R9 flag3 only");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 4'h1, "R9 shift");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 4'h2, "R9 shift");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 4'h3, "R9 flag3 at bit0");
        drive(1'b1, 1'b0, 1'b0, 4'h2, 8'h12, 4'h0, "R9 negative only");
        drive(1'b0, 1'b1, 1'b0, 4'h0, 8'h12, 4'h1, "R9 negative at bit0");

        @(negedge clk);
        load_en = 1'b0; shift_en = 1'b0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule